// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sits between a byte-wide register bus and an external analog-to-digital converter core. Software writes one control/status byte to pick an input channel, enable the interrupt and choose single-shot or free-running operation. Each such write starts a fresh conversion. The block issues a one-cycle start command to the core once the core is idle. It waits for the core's done pulse and captures the 10-bit result into a high and a low result byte. It then raises a completion flag, which can drive a level interrupt request.

A write that arrives while a conversion is in flight abandons that conversion. The done pulse that the core still delivers for it is swallowed, and the new conversion follows. The channel code is translated before it reaches the analog multiplexer: codes 0 to 7 pass through, 0x1E selects the high reference, and every other code selects the low reference (0x1F).

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, a read of the control/status byte (address 0) returns 0x01, irq is low, and mux_chan is 1.
- R2: A write to address 0 stores bits 6:0: bit 6 is interrupt enable, bit 5 is continuous mode and bits 4:0 are the channel. Bit 7 of the written byte is ignored. Bit 7 of a read is the completion flag.
- R3: Each write to address 0 yields exactly one conv_start pulse, one cycle wide, issued only while conv_busy is low, with mux_chan already showing the newly written channel.
- R4: A conv_done pulse for a live conversion sets the flag. From then on, address 1 reads {6'b0, result[9:8]} and address 2 reads result[7:0].
- R5: Reading address 1 or 2 clears the flag. Reading address 0 leaves it unchanged.
- R6: A write to address 0 clears the flag, and irq is low in the following cycle.
- R7: irq is high exactly while the interrupt enable bit and the flag are both set.
- R8: In single mode (bit 5 = 0) no further conv_start follows the completion of the requested conversion.
- R9: In continuous mode (bit 5 = 1) a new conv_start follows every completion, and the result bytes change with each completion.
- R10: mux_chan equals the channel code for 0x00–0x07 and for 0x1E. It is 0x1F for 0x1F and for every code from 0x08 to 0x1D.
- R11: When a write arrives during a conversion, the done pulse of the abandoned conversion neither sets the flag nor alters the results. The results then come from the conversion started by the write.
- R12: No conv_start occurs between reset and the first write to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control/status, 1 result high, 2 result low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| conv_start | output | 1 | One-cycle start command to the converter core |
| conv_busy | input | 1 | Converter core is converting |
| conv_done | input | 1 | One-cycle completion pulse from the core |
| conv_result | input | 10 | Conversion result, valid with conv_done |
| mux_chan | output | 5 | Translated channel code for the analog multiplexer |
| irq | output | 1 | Level interrupt request |

## Verification
Most faults in the sequencer state show up as a conv_start that is missing, extra or early, and the bench sees them within one cycle of the write or completion. Each start is compared against a queue of expected channel codes. A stale abort state shows up as a flag that rises at the abandoned done pulse, about one converter latency after the write. A wrong flag or enable bit shows up on irq and in bit 7 of the status byte on the next read.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_START = 2'd1,
    SQ_RUN   = 2'd2,
    SQ_DRAIN = 2'd3
  } seq_state_e;

  localparam int unsigned BIT_FLAG = 7;
  localparam int unsigned BIT_IE   = 6;
  localparam int unsigned BIT_CONT = 5;

  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_RHI = 2'd1;
  localparam logic [1:0] ADDR_RLO = 2'd2;
endpackage

// File: rtl/adc_seq_chan_map.sv
module adc_seq_chan_map #(
  parameter int unsigned CH_W   = 5,
  parameter int unsigned EXT_CH = 8
) (
  input  logic [CH_W-1:0] chan_code,
  output logic [CH_W-1:0] mux_code
);
  localparam logic [CH_W-1:0] LO_REF = {CH_W{1'b1}};
  localparam logic [CH_W-1:0] HI_REF = {{(CH_W-1){1'b1}}, 1'b0};
  localparam logic [CH_W-1:0] EXT_N  = CH_W'(EXT_CH);

  always_comb begin
    if (chan_code < EXT_N)       mux_code = chan_code;
    else if (chan_code == HI_REF) mux_code = HI_REF;
    else                          mux_code = LO_REF;
  end

  always_comb begin
    a_r10_legal_code: assert ((mux_code < EXT_N) || (mux_code == HI_REF) || (mux_code == LO_REF));
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic cont_mode,
  input  logic conv_busy,
  input  logic conv_done,
  output logic conv_start,
  output logic done_accept
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    conv_start  = 1'b0;
    done_accept = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (ctl_wr) state_d = SQ_START;
      end
      SQ_START: begin
        conv_start = ~conv_busy;
        if (ctl_wr)          state_d = conv_start ? SQ_DRAIN : SQ_START;
        else if (conv_start) state_d = SQ_RUN;
      end
      SQ_RUN: begin
        if (ctl_wr) begin
          state_d = conv_done ? SQ_START : SQ_DRAIN;
        end else if (conv_done) begin
          done_accept = 1'b1;
          state_d     = cont_mode ? SQ_START : SQ_IDLE;
        end
      end
      SQ_DRAIN: begin
        if (conv_done) state_d = SQ_START;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  a_r3_start_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  a_r3_start_core_idle: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !conv_busy);
  a_r11_drain_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_DRAIN) |-> !done_accept);
  a_r6_write_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (state_q == SQ_START || state_q == SQ_DRAIN));
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned CTL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             rd_res,
  input  logic             done_accept,
  input  logic [RES_W-1:0] conv_result,
  output logic [CTL_W-1:0] ctl_q,
  output logic             flag_q,
  output logic [RES_W-1:0] res_q
);
  localparam logic [CTL_W-1:0] CTL_RST = CTL_W'(1);

  logic             ctl_en, flag_en, res_en;
  logic [CTL_W-1:0] ctl_d;
  logic             flag_d;
  logic [RES_W-1:0] res_d;

  always_comb begin
    ctl_en  = ctl_wr;
    ctl_d   = ctl_wdata;
    res_en  = done_accept;
    res_d   = conv_result;
    flag_en = done_accept | ctl_wr | rd_res;
    flag_d  = done_accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CTL_RST;
      flag_q <= 1'b0;
      res_q  <= '0;
    end else begin
      if (ctl_en)  ctl_q  <= ctl_d;
      if (flag_en) flag_q <= flag_d;
      if (res_en)  res_q  <= res_d;
    end
  end

  a_r4_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_accept |=> $stable(res_q));
  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    done_accept |=> flag_q);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_res && !done_accept) |=> !flag_q);
  a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !flag_q);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RES_W  = 10,
  parameter int unsigned CH_W   = 5,
  parameter int unsigned EXT_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              conv_start,
  input  logic              conv_busy,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result,
  output logic [CH_W-1:0]   mux_chan,
  output logic              irq
);
  localparam int unsigned CTL_W = DATA_W - 1;
  localparam int unsigned HI_W  = RES_W - DATA_W;

  logic             ctl_wr, rd_res, done_accept, flag_q;
  logic [CTL_W-1:0] ctl_q;
  logic [RES_W-1:0] res_q;
  logic             wdata_flag_unused;

  assign wdata_flag_unused = bus_wdata[BIT_FLAG];

  always_comb begin
    ctl_wr = bus_sel & bus_we & (bus_addr == ADDR_CTL);
    rd_res = bus_sel & ~bus_we & ((bus_addr == ADDR_RHI) | (bus_addr == ADDR_RLO));
  end

  adc_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .cont_mode   (ctl_q[BIT_CONT]),
    .conv_busy   (conv_busy),
    .conv_done   (conv_done),
    .conv_start  (conv_start),
    .done_accept (done_accept)
  );

  adc_seq_regs #(.RES_W(RES_W), .CTL_W(CTL_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .ctl_wdata   (bus_wdata[CTL_W-1:0]),
    .rd_res      (rd_res),
    .done_accept (done_accept),
    .conv_result (conv_result),
    .ctl_q       (ctl_q),
    .flag_q      (flag_q),
    .res_q       (res_q)
  );

  adc_seq_chan_map #(.CH_W(CH_W), .EXT_CH(EXT_CH)) u_map (
    .chan_code (ctl_q[CH_W-1:0]),
    .mux_code  (mux_chan)
  );

  always_comb begin
    irq = ctl_q[BIT_IE] & flag_q;
    case (bus_addr)
      ADDR_CTL: bus_rdata = {flag_q, ctl_q};
      ADDR_RHI: bus_rdata = {{(2*DATA_W-RES_W){1'b0}}, res_q[RES_W-1:DATA_W]};
      ADDR_RLO: bus_rdata = res_q[DATA_W-1:0];
      default:  bus_rdata = '0;
    endcase
  end

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !bus_wdata[BIT_IE]) |=> !irq);
  a_r6_irq_drops_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !irq);
  initial begin
    a_r4_split_width: assert (HI_W > 0 && HI_W <= DATA_W);
  end
endmodule

// File: tb/adc_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb_top;
  localparam int LAT = 8;

  logic       clk, rst_n;
  logic       bus_sel, bus_we;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       conv_start, conv_busy, conv_done;
  logic [9:0] conv_result;
  logic [4:0] mux_chan;
  logic       irq;

  int tests, fails;
  int start_cnt, done_cnt, seq;
  int cnt;
  bit cont_free;
  logic [4:0] exp_q[$];

  adc_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_start(conv_start), .conv_busy(conv_busy), .conv_done(conv_done),
    .conv_result(conv_result), .mux_chan(mux_chan), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [9:0] mv(input int s);
    return 10'(s * 149 + 77);
  endfunction

  function automatic logic [4:0] map_ch(input logic [4:0] c);
    if (c < 5'd8) return c;
    if (c == 5'h1E) return 5'h1E;
    return 5'h1F;
  endfunction

  // converter core model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_busy <= 1'b0; conv_done <= 1'b0; cnt <= 0; seq <= 0; conv_result <= '0;
    end else begin
      conv_done <= 1'b0;
      if (conv_start) begin
        conv_busy <= 1'b1; cnt <= LAT; seq <= seq + 1; conv_result <= mv(seq + 1);
      end else if (conv_busy) begin
        if (cnt == 1) begin conv_busy <= 1'b0; conv_done <= 1'b1; done_cnt <= done_cnt + 1; end
        else cnt <= cnt - 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor on start commands
  always @(negedge clk) begin
    if (rst_n && conv_start) begin
      start_cnt++;
      check(conv_busy == 1'b0, "R3 start while busy", conv_busy, 0);
      if (!cont_free) begin
        if (exp_q.size() == 0) check(1'b0, "R3/R8/R12 unexpected start", mux_chan, 0);
        else begin
          logic [4:0] e;
          e = exp_q.pop_front();
          check(mux_chan == e, "R3/R10 start channel", mux_chan, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 2'd0; bus_wdata = d;
    if (!cont_free) exp_q.push_back(map_ch(d[4:0]));
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic finish_run;
    check(exp_q.size() == 0, "R3 missing starts", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    int s0;
    tests = 0; fails = 0; start_cnt = 0; done_cnt = 0; cont_free = 0;
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(2'd0, d);
    check(d == 8'h01, "R1 ctl reset", d, 8'h01);
    check(irq == 0, "R1 irq reset", irq, 0);
    check(mux_chan == 5'd1, "R1 mux reset", mux_chan, 1);
    repeat (20) @(negedge clk);
    check(start_cnt == 0, "R12 no start before write", start_cnt, 0);

    // R2 bit 7 ignored, R4 result, R5 clears
    wr(8'h83);
    rd(2'd0, d);
    check(d == 8'h03, "R2 flag bit not writable", d, 8'h03);
    repeat (20) @(negedge clk);
    rd(2'd0, d);
    check(d == 8'h83, "R4 flag set on done", d, 8'h83);
    rd(2'd0, d);
    check(d[7] == 1'b1, "R5 ctl read keeps flag", d[7], 1);
    rd(2'd1, d);
    check(d == {6'b0, mv(seq)[9:8]}, "R4 result high", d, {6'b0, mv(seq)[9:8]});
    rd(2'd0, d2);
    check(d2[7] == 1'b0, "R5 high read clears flag", d2[7], 0);
    rd(2'd2, d);
    check(d == mv(seq)[7:0], "R4 result low", d, mv(seq)[7:0]);
    check(start_cnt == 1, "R8 single conversion", start_cnt, 1);

    // R7 irq, R5 low read clears
    wr(8'h45);
    check(irq == 0, "R7 irq low before done", irq, 0);
    repeat (20) @(negedge clk);
    check(irq == 1, "R7 irq on done", irq, 1);
    check(mux_chan == 5'd5, "R3 mux follows write", mux_chan, 5);
    rd(2'd2, d);
    check(irq == 0, "R5 low read clears irq", irq, 0);
    wr(8'h46);
    repeat (20) @(negedge clk);
    check(irq == 1, "R7 irq again", irq, 1);
    wr(8'h00);
    check(irq == 0, "R6 write drops irq", irq, 0);
    rd(2'd0, d);
    check(d[7] == 0, "R6 write clears flag", d[7], 0);
    repeat (20) @(negedge clk);
    check(irq == 0, "R7 irq gated by enable", irq, 0);

    // R10 channel mapping
    wr(8'h0A); repeat (2) @(negedge clk);
    check(mux_chan == 5'h1F, "R10 reserved to low ref", mux_chan, 5'h1F);
    repeat (18) @(negedge clk);
    wr(8'h1D); repeat (20) @(negedge clk);
    wr(8'h1E);
    check(mux_chan == 5'h1E, "R10 high ref", mux_chan, 5'h1E);
    repeat (20) @(negedge clk);
    wr(8'h1F); repeat (20) @(negedge clk);
    wr(8'h07);
    check(mux_chan == 5'h07, "R10 external 7", mux_chan, 7);
    repeat (20) @(negedge clk);

    // R11 abort
    wr(8'h02);
    repeat (3) @(negedge clk);
    wr(8'h04);
    wait (conv_done == 1'b1);
    @(negedge clk); @(negedge clk);
    rd(2'd0, d);
    check(d[7] == 0, "R11 stale done ignored", d[7], 0);
    repeat (25) @(negedge clk);
    rd(2'd0, d);
    check(d == 8'h84, "R11 new conversion completes", d, 8'h84);
    rd(2'd2, d);
    check(d == mv(seq)[7:0], "R11 result from new conversion", d, mv(seq)[7:0]);

    // R9 continuous
    cont_free = 1;
    s0 = start_cnt;
    wr(8'h21);
    repeat (40) @(negedge clk);
    rd(2'd2, d);
    repeat (12) @(negedge clk);
    rd(2'd2, d2);
    check(start_cnt - s0 >= 3, "R9 automatic restarts", start_cnt - s0, 3);
    check(d != d2, "R9 result updates", d2, d);
    wr(8'h01);
    repeat (30) @(negedge clk);
    s0 = start_cnt;
    repeat (30) @(negedge clk);
    check(start_cnt == s0, "R8 single mode stops", start_cnt - s0, 0);
    cont_free = 0;

    finish_run();
  end
endmodule